// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an 8-bit shift register that captures a parallel word and sends it out one bit at a time, most significant stage first. A free-running system clock samples every external pin: two clock pins, an active-low load pin, a serial data input and the parallel bus. The two clock pins are merged by a logical OR. A rising edge of the merged signal moves every stage one place toward the top, and the bottom stage takes the serial input. Holding either clock pin high blocks the other, so each pin can serve as an active-low shift enable for the other.

The load is level-driven. While the load pin is low, the register keeps copying the parallel bus and ignores both clock pins. The block drives the top stage on one output and its complement on a second output. Several blocks can be chained by feeding one block's serial output into the next block's serial input.

Top module: `piso_shreg`

## Requirements
- R1: A synchronous active-high reset clears every stage, so that ser_out reads 0 and ser_out_n reads 1.
- R2: While load_n_pin is low, the register copies par_in on every system cycle, whatever the clock pins do.
- R3: A merged-clock edge seen while load is low is dropped, not queued. Releasing load afterwards, with the clock pin still high and then falling, causes no shift.
- R4: With load high, a rising edge of the merged clock shifts the register. Stage n takes stage n-1, and stage 0 takes ser_in.
- R5: With load high and no rising edge of the merged clock, the register holds its contents. A falling clock pin is one such case.
- R6: The merged clock is clk_a_pin OR clk_b_pin. A rising edge on either pin while the other pin is low causes one shift.
- R7: While one clock pin is held high, any number of pulses on the other pin cause no shift.
- R8: ser_out is the top stage (bit 7) and ser_out_n is its inverse. Immediately after a load, they show par_in[7] and its complement.
- R9: The data leaves top stage first. After eight shifts the register holds the eight serial bits, and further shifts bring them out in the order they went in.
- R10: Raising one clock pin while the other pin is already high causes no shift. Lowering it while the other pin is high also causes no shift.
- R11: A pin change that is set up before system clock edge k shows on the outputs after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| clk_a_pin | input | 1 | First external shift clock, or active-low enable |
| clk_b_pin | input | 1 | Second external shift clock, or active-low enable |
| load_n_pin | input | 1 | Active-low level-sensitive parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data, bit 7 is the top stage |
| ser_out | output | 1 | Top stage, true value |
| ser_out_n | output | 1 | Top stage, inverted value |

## Verification
The hardest case to reach is using one clock pin as an enable. The enable must rise only while the other pin is already high, and later it must fall while that pin is still high. Any other order makes a real edge on the merged clock. The stimulus first raises the active clock pin, which shifts once as expected. It then raises the enable, pulses the clock pin while the enable is held, and finally drops the enable with the clock pin high. Every step is checked for no shift.

A second hard case is a clock edge that lands during a load. The bench raises a clock pin while load is low and then releases load with that pin still high, to show the edge was dropped.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int DEF_WIDTH       = 8;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } core_op_e;

  // Load wins over an edge in the same cycle; the edge is then lost.
  function automatic core_op_e pick_op(input logic load_n, input logic edge_seen);
    if (!load_n)        return OP_LOAD;
    else if (edge_seen) return OP_SHIFT;
    else                return OP_HOLD;
  endfunction
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {W{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/piso_clk_comb.sv
module piso_clk_comb (
  input  logic clk,
  input  logic rst,
  input  logic pin_a_s,
  input  logic pin_b_s,
  output logic shift_edge
);
  logic merged;
  logic merged_q;

  assign merged = pin_a_s | pin_b_s;

  always_ff @(posedge clk) begin
    if (rst) merged_q <= 1'b0;
    else     merged_q <= merged;
  end

  assign shift_edge = merged & ~merged_q;

  // R6: a rising pin with the other pin low gives an edge
  p_pin_a_edge_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(pin_a_s) && !pin_b_s && !$past(pin_b_s)) |-> shift_edge);
  p_pin_b_edge_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(pin_b_s) && !pin_a_s && !$past(pin_a_s)) |-> shift_edge);
  // R7: a pin held high masks the other pin
  p_a_enable_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_a_s && $past(pin_a_s)) |-> !shift_edge);
  p_b_enable_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_b_s && $past(pin_b_s)) |-> !shift_edge);
  // R10: raising one pin while the other is already high is no edge
  p_safe_disable_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(pin_b_s) && pin_a_s && $past(pin_a_s)) |-> !shift_edge);
endmodule

// File: rtl/piso_core.sv
module piso_core
  import piso_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n_s,
  input  logic             sdata_s,
  input  logic [WIDTH-1:0] par_s,
  input  logic             shift_edge,
  output logic             msb
);
  logic [WIDTH-1:0] stage;
  core_op_e         op;

  function automatic logic [WIDTH-1:0] shift_up(input logic [WIDTH-1:0] cur, input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  assign op = pick_op(load_n_s, shift_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      case (op)
        OP_LOAD:  stage <= par_s;
        OP_SHIFT: stage <= shift_up(stage, sdata_s);
        default:  stage <= stage;
      endcase
    end
  end

  assign msb = stage[WIDTH-1];

  // R1: reset clears the register
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (stage == '0));
  // R2: level load copies the bus
  p_level_load_r2: assert property (@(posedge clk) disable iff (rst)
    !load_n_s |=> (stage == $past(par_s)));
  // R3: an edge during load is discarded
  p_edge_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_n_s && shift_edge) |=> (stage == $past(par_s)));
  // R4: shift toward the top, serial bit into stage 0
  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (load_n_s && shift_edge) |=>
      (stage[WIDTH-1:1] == $past(stage[WIDTH-2:0])) && (stage[0] == $past(sdata_s)));
  // R5: no edge, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (load_n_s && !shift_edge) |=> $stable(stage));
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
  import piso_pkg::*;
#(
  parameter int WIDTH       = DEF_WIDTH,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_a_pin,
  input  logic             clk_b_pin,
  input  logic             load_n_pin,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic              load_n_s;
  logic [WIDTH-1:0]  par_s;
  logic              shift_edge;
  logic              top_bit;

  piso_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ctrl (
    .clk(clk), .rst(rst), .d({clk_a_pin, clk_b_pin, ser_in}), .q(ctrl_s));

  piso_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
    .clk(clk), .rst(rst), .d(load_n_pin), .q(load_n_s));

  piso_sync #(.W(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_par (
    .clk(clk), .rst(rst), .d(par_in), .q(par_s));

  piso_clk_comb u_clk_comb (
    .clk(clk), .rst(rst), .pin_a_s(ctrl_s[2]), .pin_b_s(ctrl_s[1]),
    .shift_edge(shift_edge));

  piso_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .load_n_s(load_n_s), .sdata_s(ctrl_s[0]),
    .par_s(par_s), .shift_edge(shift_edge), .msb(top_bit));

  assign ser_out   = top_bit;
  assign ser_out_n = ~top_bit;
endmodule

// File: tb/piso_shreg_tb_top.sv
`timescale 1ns/1ps
module piso_shreg_tb_top;
  logic clk = 1'b0;
  logic rst, clk_a_pin, clk_b_pin, load_n_pin, ser_in;
  logic [7:0] par_in;
  logic ser_out, ser_out_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] ref_q;
  int unused_seed;

  always #2 clk = ~clk;

  piso_shreg dut_i (
    .clk(clk), .rst(rst), .clk_a_pin(clk_a_pin), .clk_b_pin(clk_b_pin),
    .load_n_pin(load_n_pin), .ser_in(ser_in), .par_in(par_in),
    .ser_out(ser_out), .ser_out_n(ser_out_n));

  function automatic logic [7:0] model_shift(input logic [7:0] v, input logic b);
    logic [7:0] r;
    for (int i = 7; i > 0; i--) r[i] = v[i-1];
    r[0] = b;
    return r;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp);
    n_chk++;
    if (ser_out !== exp || ser_out_n !== ~exp) begin
      n_fail++;
      $display("FAIL %s: ser_out/ser_out_n=%b/%b expected %b/%b", tag, ser_out, ser_out_n, exp, ~exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v);
    par_in = v; load_n_pin = 1'b0;
    wait_cyc(4); ref_q = v; chk("R8 load shows bit 7", ref_q[7]);
    load_n_pin = 1'b1;
    wait_cyc(4); chk("R5 hold after load release", ref_q[7]);
  endtask

  task automatic pulse(input bit use_b, input logic b);
    ser_in = b; wait_cyc(3);
    if (use_b) clk_b_pin = 1'b1; else clk_a_pin = 1'b1;
    wait_cyc(4); ref_q = model_shift(ref_q, b);
    chk(use_b ? "R6 shift on pin b" : "R4 shift on pin a", ref_q[7]);
    if (use_b) clk_b_pin = 1'b0; else clk_a_pin = 1'b0;
    wait_cyc(4); chk("R5 falling pin holds", ref_q[7]);
  endtask

  task automatic enable_seq(input logic b);
    ser_in = b; wait_cyc(3);
    clk_a_pin = 1'b1; wait_cyc(4); ref_q = model_shift(ref_q, b);
    chk("R4 shift before enable", ref_q[7]);
    ser_in = ~b;
    clk_b_pin = 1'b1; wait_cyc(4); chk("R10 enable raised while clock high", ref_q[7]);
    for (int i = 0; i < 3; i++) begin
      clk_a_pin = 1'b0; wait_cyc(3); chk("R7 gated low", ref_q[7]);
      clk_a_pin = 1'b1; wait_cyc(3); chk("R7 gated rise", ref_q[7]);
    end
    clk_b_pin = 1'b0; wait_cyc(4); chk("R10 enable dropped while clock high", ref_q[7]);
    clk_a_pin = 1'b0; wait_cyc(4); chk("R5 final fall", ref_q[7]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: run still active, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] stream;
    logic [7:0] v;
    unused_seed = $urandom(32'h0165);
    rst = 1'b1; clk_a_pin = 0; clk_b_pin = 0; load_n_pin = 1; ser_in = 0; par_in = 8'h00;
    wait_cyc(5); chk("R1 in reset", 1'b0);
    rst = 1'b0; wait_cyc(4); chk("R1 after reset", 1'b0);
    ref_q = 8'h00;

    do_load(8'hA5);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);

    // R11: latency of exactly two system edges
    v = {~ref_q[7], 7'h2C};
    @(negedge clk); par_in = v; load_n_pin = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk); chk("R11 not yet visible", ref_q[7]);
    @(posedge clk); @(negedge clk); chk("R11 visible after k+2", v[7]);
    ref_q = v; load_n_pin = 1'b1; wait_cyc(4);

    // R2: load ignores clock pulses
    par_in = 8'h80; load_n_pin = 1'b0; ref_q = 8'h80;
    for (int i = 0; i < 3; i++) begin
      clk_a_pin = 1'b1; wait_cyc(3); chk("R2 load with pin a high", 1'b1);
      clk_a_pin = 1'b0; wait_cyc(3); chk("R2 load with pin a low", 1'b1);
    end
    // R3: edge during load is dropped
    par_in = 8'h7F; ser_in = 1'b1; wait_cyc(4);
    clk_b_pin = 1'b1; wait_cyc(4); ref_q = 8'h7F;
    load_n_pin = 1'b1; wait_cyc(4); chk("R3 no queued shift", 1'b0);
    clk_b_pin = 1'b0; wait_cyc(4); chk("R3 release fall", 1'b0);

    // R9: eight shifts then stream returns in order
    do_load(8'hC3);
    stream = 8'h96;
    for (int i = 7; i >= 0; i--) pulse(i[0], stream[i]);
    for (int i = 7; i >= 0; i--) begin
      n_chk++;
      if (ref_q[7] !== stream[i] || ser_out !== stream[i]) begin
        n_fail++;
        $display("FAIL R9 stream bit %0d: actual %b expected %b", i, ser_out, stream[i]);
      end
      pulse(1'b0, 1'b0);
    end

    // R6: raising pin b while pin a low is a real edge
    pulse(1'b1, 1'b1);
    enable_seq(1'b1);

    for (int it = 0; it < 150; it++) begin
      case ($urandom_range(3))
        0: do_load(8'($urandom));
        1: pulse(1'b0, 1'($urandom));
        2: pulse(1'b1, 1'($urandom));
        default: enable_seq(1'($urandom));
      endcase
    end

    rst = 1'b1; wait_cyc(2); chk("R1 mid-run reset", 1'b0);
    rst = 1'b0; wait_cyc(2);

    done = 1;
    summary();
    $finish;
  end
endmodule